// File: doc/BRIEF.md
# Phase-Aligned PWM Time-Base Clock Gate

This block produces one time-base tick enable per PWM channel from a single system clock. Each channel divides the system clock by its own programmable prescale value. A single global run control starts and stops every channel's divider at once. While that control is low, every divider counter is held at zero. When the control goes high, all dividers leave zero on the same cycle, so the first ticks of all enabled channels coincide. Channels with equal prescale values then stay in phase for as long as the run control stays high.

Each channel also has its own enable. The enable gates only the tick output of that channel. The divider behind it keeps counting, so a channel that is enabled again later is still in phase with the other channels. The prescale value is captured only while the block is halted. A change made while running has no effect until the next halt.

A second function takes the synchronization pulse of channel 0 and widens it to a fixed window of system-clock cycles before it is sent off chip. A new pulse that arrives inside the window restarts the window.

The global controller has two states. In GATE_HALT the counters are held at zero and the prescale values are loaded. GATE_HALT moves to GATE_RUN on the edge where `sync_en` is sampled high. In GATE_RUN the counters run. GATE_RUN moves back to GATE_HALT on the edge where `sync_en` is sampled low. The stretcher also has two states. STR_IDLE moves to STR_HOLD on a sampled `sync_in`. STR_HOLD reloads its window on each further `sync_in` and returns to STR_IDLE when the window runs out.

Top module: `pwm_timebase_gate`

## Requirements
- R1: During and right after reset, all `tb_tick` bits and `sync_out` are 0.
- R2: While the controller is in GATE_HALT, no `tb_tick` bit is 1. The controller is in GATE_HALT in the cycle after any edge where `sync_en` was sampled 0.
- R3: After the edge where `sync_en` is first sampled 1, every channel whose `ch_en` bit is 1 asserts its `tb_tick` bit in the very next cycle. All these first ticks fall on that same cycle.
- R4: A running channel with prescale value N (bits [ch*PRESC_W +: PRESC_W] of `ch_presc`) ticks once every N+1 cycles. The first of these ticks is the start tick of R3.
- R5: Channels with equal prescale values tick on exactly the same cycles for the whole run.
- R6: A channel whose `ch_en` bit is 0 never ticks. Its divider keeps running, so after re-enabling it ticks on the cycles given by R4, counted from the common start.
- R7: The divider captures `ch_presc` only while the controller is in GATE_HALT. A change made during GATE_RUN leaves the tick spacing unchanged.
- R8: After an edge where `sync_in` is sampled 1, `sync_out` is 1 for exactly STRETCH (default 8) cycles, starting in the next cycle.
- R9: A `sync_in` pulse sampled while `sync_out` is high restarts the window. `sync_out` then stays high for STRETCH cycles after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_en | input | 1 | Global run control for all time-bases |
| ch_en | input | NUM_CH | Per-channel tick enable |
| ch_presc | input | NUM_CH*PRESC_W | Per-channel prescale values; channel c uses bits [c*PRESC_W +: PRESC_W] |
| tb_tick | output | NUM_CH | Per-channel time-base tick, one cycle wide |
| sync_in | input | 1 | Raw sync pulse from channel 0 |
| sync_out | output | 1 | Stretched sync pulse for export |

## Verification
A controller stuck in the wrong state shows up at the ports within one cycle. Ticks then appear while halted, or the expected start tick is missing on the cycle after `sync_en` rises. A divider counter that is off by even one shows up as a tick on the wrong cycle, at the latest N+1 cycles after the start. It also breaks the lock-step between channels that share a prescale value. A wrong stretch counter shows up as a `sync_out` window that is too short or too long. It shows up within STRETCH+1 cycles of a pulse, and a retriggered window exposes a counter that failed to reload.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

    typedef enum logic {
        GATE_HALT = 1'b0,
        GATE_RUN  = 1'b1
    } gate_state_t;

    typedef enum logic {
        STR_IDLE = 1'b0,
        STR_HOLD = 1'b1
    } str_state_t;

endpackage

// File: rtl/tbg_gate_fsm.sv
module tbg_gate_fsm
    import tbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    output logic run
);
    gate_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_HALT: if (sync_en)  state_d = GATE_RUN;
            GATE_RUN:  if (!sync_en) state_d = GATE_HALT;
            default:   state_d = GATE_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == GATE_RUN);
    end
endmodule

// File: rtl/tbg_prescaler.sv
module tbg_prescaler #(
    parameter int PRESC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc_in,
    output logic               tick
);
    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] cnt_q;

    // prescale value is captured only while halted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    presc_q <= '0;
        else if (!run) presc_q <= presc_in;
    end

    // counter held at zero while halted; runs regardless of en to keep phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q == presc_q) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        tick = run && en && (cnt_q == '0);
    end
endmodule

// File: rtl/tbg_sync_stretch.sv
module tbg_sync_stretch
    import tbg_pkg::*;
#(
    parameter int STRETCH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic pulse_out
);
    localparam int CW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [CW-1:0] LOAD = CW'(STRETCH - 1);

    str_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            STR_IDLE: begin
                if (pulse_in) begin
                    state_d = STR_HOLD;
                    cnt_d   = LOAD;
                end
            end
            STR_HOLD: begin
                if (pulse_in) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = STR_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = STR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pulse_out = (state_q == STR_HOLD);
    end
endmodule

// File: rtl/pwm_timebase_gate.sv
module pwm_timebase_gate #(
    parameter int NUM_CH  = 4,
    parameter int PRESC_W = 4,
    parameter int STRETCH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sync_en,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH*PRESC_W-1:0] ch_presc,
    output logic [NUM_CH-1:0]         tb_tick,
    input  logic                      sync_in,
    output logic                      sync_out
);
    logic run;

    tbg_gate_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_en (sync_en),
        .run     (run)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tbg_prescaler #(.PRESC_W(PRESC_W)) u_presc (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .en       (ch_en[c]),
            .presc_in (ch_presc[c*PRESC_W +: PRESC_W]),
            .tick     (tb_tick[c])
        );
    end

    tbg_sync_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_in  (sync_in),
        .pulse_out (sync_out)
    );
endmodule

// File: rtl/pwm_timebase_gate_chk.sv
module pwm_timebase_gate_chk #(
    parameter int NUM_CH  = 4,
    parameter int STRETCH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_en,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] tb_tick,
    input logic              sync_in,
    input logic              sync_out
);
    int since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_q <= STRETCH;
        else if (sync_in)          since_q <= 0;
        else if (since_q < STRETCH) since_q <= since_q + 1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (tb_tick == '0 && !sync_out));

    a_r2_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_en) |-> tb_tick == '0);

    a_r3_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_en) && !$past(sync_en, 2)) |-> tb_tick == ch_en);

    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_tick & ~ch_en) == '0);

    a_r8_stretch_start: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> sync_out);

    a_r9_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out == (since_q < STRETCH));
endmodule

bind pwm_timebase_gate pwm_timebase_gate_chk #(
    .NUM_CH  (NUM_CH),
    .STRETCH (STRETCH)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_en  (sync_en),
    .ch_en    (ch_en),
    .tb_tick  (tb_tick),
    .sync_in  (sync_in),
    .sync_out (sync_out)
);

// File: tb/test_pwm_timebase_gate.sv
module test_pwm_timebase_gate;
    localparam int NUM_CH  = 4;
    localparam int PRESC_W = 4;
    localparam int STRETCH = 8;

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic                      sync_en;
    logic [NUM_CH-1:0]         ch_en;
    logic [NUM_CH*PRESC_W-1:0] ch_presc;
    logic [NUM_CH-1:0]         tb_tick;
    logic                      sync_in;
    logic                      sync_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pwm_timebase_gate #(.NUM_CH(NUM_CH), .PRESC_W(PRESC_W), .STRETCH(STRETCH)) i_pwm_timebase_gate (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .ch_en(ch_en),
        .ch_presc(ch_presc), .tb_tick(tb_tick), .sync_in(sync_in), .sync_out(sync_out)
    );

    // reference state derived from the requirements
    bit run_m;
    int t_m;
    int presc_m [NUM_CH];
    int since_m;
    bit retrig_m;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_m    <= 1'b0;
            t_m      <= 0;
            since_m  <= STRETCH;
            retrig_m <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) presc_m[c] <= 0;
        end else begin
            if (!run_m)
                for (int c = 0; c < NUM_CH; c++) presc_m[c] <= int'(ch_presc[c*PRESC_W +: PRESC_W]);
            t_m   <= (sync_en && !run_m) ? 0 : t_m + 1;
            run_m <= sync_en;
            if (sync_in) begin
                retrig_m <= (since_m < STRETCH);
                since_m  <= 0;
            end else if (since_m < STRETCH) begin
                since_m <= since_m + 1;
            end
        end
    end

    function automatic bit exp_tick(bit run, bit en, int t, int n);
        return run && en && ((t % (n + 1)) == 0);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // called after a falling edge: compare all outputs to the model
    task automatic check_all();
        for (int c = 0; c < NUM_CH; c++) begin
            string req;
            if (!run_m)                   req = "R2";
            else if (!ch_en[c])           req = "R6";
            else if (t_m == 0)            req = "R3";
            else if (int'(ch_presc[c*PRESC_W +: PRESC_W]) != presc_m[c]) req = "R7";
            else                          req = "R4";
            chk(req, int'(tb_tick[c]), int'(exp_tick(run_m, ch_en[c], t_m, presc_m[c])));
        end
        chk(retrig_m ? "R9" : "R8", int'(sync_out), int'(since_m < STRETCH));
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog act=0 exp=1");
        bad++;
        total++;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n    = 1'b0;
        sync_en  = 1'b1;
        ch_en    = '1;
        ch_presc = '0;
        sync_in  = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", int'(tb_tick), 0);
        chk("R1", int'(sync_out), 0);
        sync_en = 1'b0;
        sync_in = 1'b0;
        rst_n   = 1'b1;
        step();

        // directed R5: all channels equal prescale, common start
        ch_presc = {NUM_CH{4'd3}};
        ch_en    = '1;
        step();
        sync_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            step();
            chk("R5", int'(tb_tick == '0 || tb_tick == '1), 1);
            ch_presc = $urandom;  // R7: ignored while running
        end
        // R6: disable channel 1 then re-enable; phase kept
        ch_en = 4'b1101;
        for (int i = 0; i < 9; i++) step();
        ch_en = 4'b1111;
        for (int i = 0; i < 12; i++) begin
            step();
            chk("R5", int'(tb_tick == '0 || tb_tick == '1), 1);
        end
        sync_en = 1'b0;
        step();
        step();

        // directed R8 and R9
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
        for (int i = 0; i < 4; i++) step();
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
        for (int i = 0; i < 12; i++) step();

        // directed R3 with unequal prescales, presc 0 boundary
        ch_presc = {4'd15, 4'd5, 4'd1, 4'd0};
        step();
        sync_en = 1'b1;
        for (int i = 0; i < 40; i++) step();
        sync_en = 1'b0;
        step();

        // random mix
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(39) == 0) sync_en = ~sync_en;
            for (int c = 0; c < NUM_CH; c++)
                if ($urandom_range(15) == 0) ch_en[c] = ~ch_en[c];
            if ($urandom_range(7) == 0) ch_presc = $urandom;
            sync_in = ($urandom_range(11) == 0);
            step();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule